// File: doc/BRIEF.md
# Sparse Machine-Mode CSR File

This unit serves a small RISC-V core as its machine-level control and status register store. The core presents one access per cycle: a 12-bit register address, a 3-bit operation code, the source value (or a 5-bit immediate), and two flags that say whether the source or the destination register is x0. In the same cycle the unit returns the prior register value and an illegal-access flag. On the next rising clock edge it commits the new value.

The 4096-entry address space is only sparsely populated. Four registers hold state: the trap vector, scratch, exception PC and trap cause. A handful of others are hard-wired constants: the ISA description and the vendor, architecture, implementation and hart identifiers. Every other address is rejected. The x0 flags decide whether a read or a write takes place. No register has a side effect when it is read or written, so a suppressed read changes nothing apart from the returned value.

A separate trap port lets trap-entry logic load the exception PC and the cause directly.

Top module: `csr_file`

## Requirements
- R1: After reset, the trap vector holds parameter TVEC_RST (default 64'h100), and scratch, exception PC and cause hold zero.
- R2: The writable registers sit at 0x305 (trap vector), 0x340 (scratch), 0x341 (exception PC) and 0x342 (cause). A legal access that performs a read returns the current contents on old_o in the same cycle, and each register's value is driven on its own output.
- R3: Address 0x301 reads 64'h8000_0000_0000_0100, which means 64-bit width with the base integer bit 8 set. Addresses 0xF11 to 0xF14 read zero. A write to 0x301 is legal and ignored.
- R4: op_i encodes the operations as follows. 001 writes, 010 sets bits, 011 clears bits, and 101, 110 and 111 are the same three using the zero-extended zimm_i as operand. A write loads the operand on the next edge.
- R5: Set ORs the operand into the register. Clear ANDs the register with the inverted operand.
- R6: A write operation (001 or 101) with rd_zero_i high returns zero on old_o and still performs the write.
- R7: A set or clear whose source is x0 (register form, rs1_zero_i high) or whose immediate is 0 writes nothing. It ignores rs1_val_i, and it is legal even on a read-only address.
- R8: An access is illegal if the address is unimplemented, if op_i is 000 or 100, or if it performs a write to an address whose bits [11:10] are 11. An illegal access raises illegal_o, returns zero on old_o and changes no register.
- R9: Bits [1:0] of the exception PC always read zero.
- R10: trap_we_i loads the exception PC (with bits [1:0] cleared) and the cause on the next edge. It takes priority over a CSR write to those registers in the same cycle.
- R11: With req_i low, no register changes except through the trap port, and illegal_o and old_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access valid this cycle |
| addr_i | input | 12 | Register address |
| op_i | input | 3 | Operation code |
| rs1_val_i | input | XLEN | Source register value |
| zimm_i | input | 5 | Immediate operand |
| rs1_zero_i | input | 1 | Source register is x0 |
| rd_zero_i | input | 1 | Destination register is x0 |
| trap_we_i | input | 1 | Trap port write strobe |
| trap_cause_i | input | XLEN | Cause value for trap port |
| trap_pc_i | input | XLEN | PC value for trap port |
| old_o | output | XLEN | Prior register value |
| illegal_o | output | 1 | Illegal access flag |
| tvec_o | output | XLEN | Trap vector contents |
| scratch_o | output | XLEN | Scratch contents |
| epc_o | output | XLEN | Exception PC contents |
| cause_o | output | XLEN | Cause contents |

## Verification
The random part of the bench mixes the implemented addresses, read-only addresses without backing storage and fully random addresses. It combines these with all eight op codes and x0 flags and immediates that are zero about a quarter of the time. This separates the suppressed-write cases from real writes and separates the legal cases from the illegal ones. Directed cases then pin down the behaviour the random mix rarely reaches: the constant ISA value under an attempted write, a set with x0 source on a read-only identifier against a write to it, a write with x0 destination, low exception-PC bits, and a trap strobe colliding with a CSR write to the cause. An idle request carrying hostile operands shows whether the request gate holds.

// File: rtl/csr_file_pkg.sv
package csr_file_pkg;
  localparam int unsigned NUM_RW = 4;

  typedef enum logic [1:0] {
    RW_TVEC    = 2'd0,
    RW_SCRATCH = 2'd1,
    RW_EPC     = 2'd2,
    RW_CAUSE   = 2'd3
  } rw_idx_e;

  localparam logic [11:0] A_ISA    = 12'h301;
  localparam logic [11:0] A_VENDOR = 12'hF11;
  localparam logic [11:0] A_ARCH   = 12'hF12;
  localparam logic [11:0] A_IMPL   = 12'hF13;
  localparam logic [11:0] A_HART   = 12'hF14;

  localparam logic [11:0] RW_ADDR [NUM_RW] = '{12'h305, 12'h340, 12'h341, 12'h342};

  // op_i[2] selects immediate form, op_i[1:0] picks write/set/clear
  localparam logic [1:0] F_WRITE = 2'b01;
  localparam logic [1:0] F_SET   = 2'b10;
  localparam logic [1:0] F_CLEAR = 2'b11;
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
  import csr_file_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [11:0]       addr_i,
  output logic              hit_o,
  output logic              ro_o,
  output logic              rw_hit_o,
  output logic [NUM_RW-1:0] rw_sel_o,
  output logic [XLEN-1:0]   const_o
);
  localparam logic [1:0] MXL = (XLEN == 64) ? 2'd2 : 2'd1;
  localparam logic [XLEN-1:0] ISA_VAL = {MXL, {(XLEN-11){1'b0}}, 9'h100};

  logic const_hit;

  for (genvar i = 0; i < NUM_RW; i++) begin : g_sel
    assign rw_sel_o[i] = (addr_i == RW_ADDR[i]);
  end

  always_comb begin
    const_hit = 1'b1;
    const_o   = '0;
    unique case (addr_i)
      A_ISA:                            const_o = ISA_VAL;
      A_VENDOR, A_ARCH, A_IMPL, A_HART: const_o = '0;
      default:                          const_hit = 1'b0;
    endcase
  end

  assign rw_hit_o = |rw_sel_o;
  assign hit_o    = rw_hit_o | const_hit;
  assign ro_o     = (addr_i[11:10] == 2'b11);
endmodule

// File: rtl/csr_alu.sv
module csr_alu
  import csr_file_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [4:0]      zimm_i,
  input  logic            rs1_zero_i,
  input  logic            rd_zero_i,
  output logic [XLEN-1:0] new_o,
  output logic            wr_o,
  output logic            rd_o,
  output logic            op_ok_o
);
  logic            imm;
  logic [XLEN-1:0] operand;
  logic            src_zero;

  assign imm      = op_i[2];
  assign operand  = imm ? XLEN'(zimm_i) : rs1_val_i;
  assign src_zero = imm ? (zimm_i == 5'd0) : rs1_zero_i;

  always_comb begin
    new_o   = old_i;
    wr_o    = 1'b0;
    rd_o    = 1'b0;
    op_ok_o = 1'b1;
    unique case (op_i[1:0])
      F_WRITE: begin
        new_o = operand;
        wr_o  = 1'b1;
        rd_o  = !rd_zero_i;
      end
      F_SET: begin
        new_o = old_i | operand;
        wr_o  = !src_zero;
        rd_o  = 1'b1;
      end
      F_CLEAR: begin
        new_o = old_i & ~operand;
        wr_o  = !src_zero;
        rd_o  = 1'b1;
      end
      default: op_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/csr_file.sv
module csr_file
  import csr_file_pkg::*;
#(
  parameter int unsigned     XLEN     = 64,
  parameter logic [XLEN-1:0] TVEC_RST = XLEN'(64'h100)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [11:0]     addr_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [4:0]      zimm_i,
  input  logic            rs1_zero_i,
  input  logic            rd_zero_i,
  input  logic            trap_we_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_pc_i,
  output logic [XLEN-1:0] old_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] tvec_o,
  output logic [XLEN-1:0] scratch_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o
);
  logic              hit, ro, rw_hit;
  logic [NUM_RW-1:0] rw_sel;
  logic [XLEN-1:0]   const_val, rd_val, new_val;
  logic              wr, rd, op_ok, legal, wr_en;
  logic [XLEN-1:0]   regs_q [NUM_RW];

  csr_addr_dec #(.XLEN(XLEN)) u_dec (
    .addr_i   (addr_i),
    .hit_o    (hit),
    .ro_o     (ro),
    .rw_hit_o (rw_hit),
    .rw_sel_o (rw_sel),
    .const_o  (const_val)
  );

  always_comb begin
    rd_val = rw_hit ? '0 : const_val;
    for (int i = 0; i < NUM_RW; i++) begin
      if (rw_sel[i]) rd_val = rd_val | regs_q[i];
    end
  end

  csr_alu #(.XLEN(XLEN)) u_alu (
    .op_i       (op_i),
    .old_i      (rd_val),
    .rs1_val_i  (rs1_val_i),
    .zimm_i     (zimm_i),
    .rs1_zero_i (rs1_zero_i),
    .rd_zero_i  (rd_zero_i),
    .new_o      (new_val),
    .wr_o       (wr),
    .rd_o       (rd),
    .op_ok_o    (op_ok)
  );

  assign legal     = hit && op_ok && !(wr && ro);
  assign illegal_o = req_i && !legal;
  assign old_o     = (req_i && legal && rd) ? rd_val : '0;
  assign wr_en     = req_i && legal && wr && rw_hit;

  for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
    localparam bit IS_EPC   = (i == int'(RW_EPC));
    localparam bit IS_CAUSE = (i == int'(RW_CAUSE));
    localparam logic [XLEN-1:0] WMASK = IS_EPC ? ~XLEN'(3) : '1;
    localparam logic [XLEN-1:0] RSTV  = (i == int'(RW_TVEC)) ? TVEC_RST : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      regs_q[i] <= RSTV;
      else if (trap_we_i && IS_EPC)     regs_q[i] <= trap_pc_i & WMASK;
      else if (trap_we_i && IS_CAUSE)   regs_q[i] <= trap_cause_i;
      else if (wr_en && rw_sel[i])      regs_q[i] <= new_val & WMASK;
    end
  end

  assign tvec_o    = regs_q[RW_TVEC];
  assign scratch_o = regs_q[RW_SCRATCH];
  assign epc_o     = regs_q[RW_EPC];
  assign cause_o   = regs_q[RW_CAUSE];
endmodule

// File: rtl/csr_file_chk.sv
module csr_file_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [2:0]      op_i,
  input logic [4:0]      zimm_i,
  input logic            rs1_zero_i,
  input logic            rd_zero_i,
  input logic            trap_we_i,
  input logic [XLEN-1:0] trap_cause_i,
  input logic [XLEN-1:0] trap_pc_i,
  input logic [XLEN-1:0] old_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] tvec_o,
  input logic [XLEN-1:0] scratch_o,
  input logic [XLEN-1:0] epc_o,
  input logic [XLEN-1:0] cause_o
);
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i && !trap_we_i |=> $stable(tvec_o) && $stable(scratch_o) && $stable(epc_o) && $stable(cause_o));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !illegal_o && old_o == '0);

  assert_illegal_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && illegal_o && !trap_we_i |=> $stable(tvec_o) && $stable(scratch_o) && $stable(epc_o) && $stable(cause_o));

  assert_illegal_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> old_o == '0);

  assert_epc_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_o[1:0] == 2'b00);

  assert_trap_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_we_i |=> cause_o == $past(trap_cause_i) && epc_o == {$past(trap_pc_i[XLEN-1:2]), 2'b00});

  assert_x0_src_nowrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !illegal_o && op_i[1] && (op_i[2] ? zimm_i == 5'd0 : rs1_zero_i) && !trap_we_i
    |=> $stable(tvec_o) && $stable(scratch_o) && $stable(epc_o) && $stable(cause_o));

  assert_x0_dst_noread_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && op_i[1:0] == 2'b01 && rd_zero_i |-> old_o == '0);
endmodule

bind csr_file csr_file_chk #(.XLEN(XLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .op_i         (op_i),
  .zimm_i       (zimm_i),
  .rs1_zero_i   (rs1_zero_i),
  .rd_zero_i    (rd_zero_i),
  .trap_we_i    (trap_we_i),
  .trap_cause_i (trap_cause_i),
  .trap_pc_i    (trap_pc_i),
  .old_o        (old_o),
  .illegal_o    (illegal_o),
  .tvec_o       (tvec_o),
  .scratch_o    (scratch_o),
  .epc_o        (epc_o),
  .cause_o      (cause_o)
);

// File: tb/csr_file_tb.sv
module csr_file_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] TVEC_RST = 64'h100;
  localparam logic [63:0] ISA_VAL  = 64'h8000_0000_0000_0100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [2:0]  op_i = '0;
  logic [63:0] rs1_val_i = '0;
  logic [4:0]  zimm_i = '0;
  logic        rs1_zero_i = 1'b0;
  logic        rd_zero_i = 1'b0;
  logic        trap_we_i = 1'b0;
  logic [63:0] trap_cause_i = '0;
  logic [63:0] trap_pc_i = '0;
  logic [63:0] old_o, tvec_o, scratch_o, epc_o, cause_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] m [4];  // tvec, scratch, epc, cause

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  csr_file u_dut (.*);

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int rw_index(input logic [11:0] a);
    case (a)
      12'h305: return 0;
      12'h340: return 1;
      12'h341: return 2;
      12'h342: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit const_hit(input logic [11:0] a, output logic [63:0] v);
    v = '0;
    if (a == 12'h301) begin v = ISA_VAL; return 1; end
    return (a >= 12'hF11 && a <= 12'hF14);
  endfunction

  task automatic check_regs(input string tag);
    check({tag, " tvec"},    tvec_o,    m[0]);
    check({tag, " scratch"}, scratch_o, m[1]);
    check({tag, " epc"},     epc_o,     m[2]);
    check({tag, " cause"},   cause_o,   m[3]);
  endtask

  task automatic access(input bit req, input logic [11:0] a, input logic [2:0] op,
                        input logic [63:0] rs1, input bit rs1z, input logic [4:0] zi,
                        input bit rdz, input bit twe, input logic [63:0] tc,
                        input logic [63:0] tpc, input string tag);
    logic [63:0] cval, oldv, opnd, nv, e_old;
    int idx;
    bit hit, rd, wr, ok, srcz, legal, e_ill;
    @(negedge clk_i);
    req_i = req; addr_i = a; op_i = op; rs1_val_i = rs1; rs1_zero_i = rs1z;
    zimm_i = zi; rd_zero_i = rdz; trap_we_i = twe; trap_cause_i = tc; trap_pc_i = tpc;
    idx  = rw_index(a);
    hit  = const_hit(a, cval) || idx >= 0;
    oldv = idx >= 0 ? m[idx] : cval;
    opnd = op[2] ? {59'd0, zi} : rs1;
    srcz = op[2] ? (zi == 0) : rs1z;
    ok = 1; wr = 0; rd = 1; nv = oldv;
    case (op[1:0])
      2'b01: begin nv = opnd; wr = 1; rd = !rdz; end
      2'b10: begin nv = oldv | opnd; wr = !srcz; end
      2'b11: begin nv = oldv & ~opnd; wr = !srcz; end
      default: ok = 0;
    endcase
    legal = hit && ok && !(wr && a[11:10] == 2'b11);
    e_ill = req && !legal;
    e_old = (req && legal && rd) ? oldv : '0;
    #1;
    check({tag, " old"}, old_o, e_old);
    check({tag, " illegal"}, {63'd0, illegal_o}, {63'd0, e_ill});
    if (req && legal && wr && idx >= 0) m[idx] = (idx == 2) ? (nv & ~64'd3) : nv;
    if (twe) begin m[2] = tpc & ~64'd3; m[3] = tc; end
    @(posedge clk_i); #1;
    check_regs(tag);
  endtask

  task automatic op_(input logic [11:0] a, input logic [2:0] op, input logic [63:0] rs1,
                     input logic [4:0] zi, input string tag);
    access(1, a, op, rs1, rs1 == 0, zi, 0, 0, '0, '0, tag);
  endtask

  initial begin
    m[0] = TVEC_RST; m[1] = '0; m[2] = '0; m[3] = '0;
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk_i);
    #1; check_regs("R1 reset");
    @(negedge clk_i); rst_ni = 1'b1;

    op_(12'h340, 3'b001, 64'hDEAD_BEEF_0123_4567, 0, "R2 R4 write scratch");
    op_(12'h340, 3'b010, 64'hF000_0000_0000_0000, 0, "R5 set scratch");
    op_(12'h340, 3'b011, 64'h0000_0000_0000_00FF, 0, "R5 clear scratch");
    op_(12'h305, 3'b101, '0, 5'd31, "R4 imm write tvec");
    op_(12'h305, 3'b110, '0, 5'd0, "R7 imm zero set");
    op_(12'h305, 3'b111, '0, 5'd3, "R4 R5 imm clear tvec");
    op_(12'h301, 3'b010, '0, 0, "R3 read isa");
    op_(12'h301, 3'b001, 64'h1234, 0, "R3 write isa ignored");
    op_(12'hF12, 3'b010, '0, 0, "R3 arch id");
    access(1, 12'hF11, 3'b010, 64'hFFFF, 1, 0, 0, 0, '0, '0, "R7 x0 set on ro");
    op_(12'hF11, 3'b001, 64'h5, 0, "R8 write ro");
    op_(12'h7C0, 3'b010, '0, 0, "R8 unimplemented");
    op_(12'h340, 3'b000, 64'h1, 0, "R8 bad op");
    op_(12'h340, 3'b100, 64'h1, 0, "R8 bad op4");
    access(1, 12'h342, 3'b001, 64'h77, 0, 0, 1, 0, '0, '0, "R6 x0 dest write");
    op_(12'h341, 3'b001, 64'hABCD_EF07, 0, "R9 epc low bits");
    access(1, 12'h342, 3'b001, 64'h99, 0, 0, 0, 1, 64'h8000_0000_0000_000B,
           64'h4003, "R10 trap over write");
    access(0, 12'h340, 3'b001, 64'hFFFF, 0, 0, 0, 0, '0, '0, "R11 idle");

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [11:0] pool [11];
      pool = '{12'h305, 12'h340, 12'h341, 12'h342, 12'h301, 12'hF11, 12'hF12,
               12'hF13, 12'hF14, 12'hC00, 12'h7C0};
      a = ($urandom % 8 == 0) ? 12'($urandom) : pool[$urandom % 11];
      access(($urandom % 8) != 0, a, 3'($urandom), {$urandom, $urandom},
             ($urandom % 4) == 0, ($urandom % 4) == 0 ? 5'd0 : 5'($urandom),
             ($urandom % 4) == 0, ($urandom % 16) == 0, {$urandom, $urandom},
             {$urandom, $urandom}, "R2 R4 R5 R6 R7 R8 R10 R11 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule